// File: doc/BRIEF.md
# Re-encode Bit Error Rate Estimator

This block sits beside a convolutional (Viterbi) decoder and estimates how many channel symbols arrived in error, with no known reference pattern. Each decoded bit is run through a local convolutional encoder built from the same generator polynomials as the transmitter. The regenerated code bits are compared with the hard decisions of the received soft symbols. Those symbols are supplied by an external delay line, so each group is already aligned with the decoded bits it produced. Every disagreement on a symbol that was not erased counts as one estimated channel error.

The decoder may deliver several bits per output strobe. Measurement windows are therefore counted in strobes, not bits, and a window holds BPS times as many bits as the period value. Two counts are kept. A live count rises as errors are found, so individual error positions can be seen. A held count carries the total of the last completed window. The traceback depth parameter must be an exact multiple of BPS, and elaboration stops when it is not.

Top module: `ber_reencode_estimator`

## Requirements
- R1: While `rstN` is low, `liveCount` and `lastCount` are zero, and the encoder history is cleared to all zeros.
- R2: Decoded bit order in `decBits` is MSB earliest. Each decoded bit owns a slot of N_CODED symbols in `rxSyms`, and the earliest bit owns the most significant slot. Inside a slot, the symbol for polynomial `POLY[N_CODED-1]` sits in the most significant position and `POLY[0]` in the least. Each code bit is the XOR of the bits selected by its polynomial. Polynomial bit CONSTR-1 selects the current decoded bit, and bit CONSTR-1-m selects the bit decoded m positions earlier. The history carries across strobes.
- R3: The hard decision of a symbol is its MSB, where 1 means code bit one. A symbol is erased when all of its bits are zero, and an erased symbol never counts as an error.
- R4: One clock after a cycle with `decValid` high, `liveCount` has risen by the number of non-erased symbols of that strobe whose hard decision differs from the regenerated code bit.
- R5: In a cycle with `decValid` low, neither count changes, and neither the inputs nor the encoder history are used.
- R6: While `period` is non-zero, strobes are tallied. The strobe that brings the tally to `period` or more closes the window. On the next clock, `lastCount` holds the window total including that strobe's errors, `liveCount` is zero, and the tally restarts.
- R7: While `period` is zero, no window closes, `lastCount` holds, and the strobe tally is kept at zero.
- R8: `liveCount` saturates at all ones and does not wrap. A window closing while saturated loads all ones into `lastCount`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| decValid | input | 1 | Decoded bits and aligned symbols are present this cycle |
| decBits | input | BPS | Decoded bits, MSB earliest |
| rxSyms | input | BPS*N_CODED*SOFT_W | Delayed received soft symbols aligned with `decBits` |
| period | input | PERIOD_W (24) | Window length in strobes; zero disables rollover |
| liveCount | output | CNT_W (16) | Errors found so far in the current window |
| lastCount | output | CNT_W (16) | Error total of the previous window |

## Verification
The bench targets the seams where an estimator of this kind usually breaks. The first is the encoder history crossing a strobe boundary: a design that drops or reverses that history miscounts errors in the first bits of every strobe. The bench also feeds all-zero symbols, which a design without erasure detection would count as mismatches against code ones. At the window edge it checks that the closing strobe's errors land in the held count and not in the next window, including period values of one and period changes in the middle of a window. Finally, the bench drives the live count to its ceiling, where a wrapping counter would fall back to a small value.

// File: rtl/ber_pkg.sv
package ber_pkg;
  // Strobes from the window control into the count datapath
  typedef struct packed {
    logic accum;     // add this strobe's error tally
    logic rollover;  // this strobe closes the window
  } winCtrl_t;
endpackage

// File: rtl/ber_reencode.sv
module ber_reencode #(
  parameter int N_CODED = 2,
  parameter int CONSTR  = 7,
  parameter int SOFT_W  = 3,
  parameter int BPS     = 2,
  parameter logic [N_CODED-1:0][CONSTR-1:0] POLY = {7'o133, 7'o171},
  parameter int ERR_W   = $clog2(BPS*N_CODED+1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          decValid,
  input  logic [BPS-1:0]                decBits,
  input  logic [BPS*N_CODED*SOFT_W-1:0] rxSyms,
  output logic [ERR_W-1:0]              errCnt
);
  localparam int HIST_W = CONSTR - 1;
  localparam int EXT_W  = HIST_W + BPS;
  localparam int SLOT_W = N_CODED * SOFT_W;

  logic [HIST_W-1:0] hist;
  logic [EXT_W-1:0]  ext;

  // Oldest history bit at the top, newest decoded bit at index 0
  assign ext = {hist, decBits};

  always_comb begin
    logic [CONSTR-1:0] win;
    logic [SOFT_W-1:0] sym;
    logic              coded;
    errCnt = '0;
    for (int b = 0; b < BPS; b++) begin
      for (int m = 0; m < CONSTR; m++) begin
        win[m] = ext[b + CONSTR - 1 - m];
      end
      for (int s = 0; s < N_CODED; s++) begin
        coded = ^(win & POLY[N_CODED-1-s]);
        sym   = rxSyms[b*SLOT_W + (N_CODED-1-s)*SOFT_W +: SOFT_W];
        if ((sym != '0) && (sym[SOFT_W-1] != coded)) begin
          errCnt = errCnt + ERR_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist <= '0;
    end else if (decValid) begin
      hist <= ext[HIST_W-1:0];
    end
  end
endmodule

// File: rtl/ber_window_ctrl.sv
module ber_window_ctrl
  import ber_pkg::*;
#(
  parameter int PERIOD_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                decValid,
  input  logic [PERIOD_W-1:0] period,
  output winCtrl_t            ctrl
);
  logic [PERIOD_W-1:0] strobeCnt;
  logic [PERIOD_W:0]   nextCnt;
  logic                windowOn;

  assign windowOn = (period != '0);
  assign nextCnt  = {1'b0, strobeCnt} + (PERIOD_W+1)'(1);

  always_comb begin
    ctrl.accum    = decValid;
    ctrl.rollover = decValid && windowOn && (nextCnt >= {1'b0, period});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobeCnt <= '0;
    end else if (!windowOn || ctrl.rollover) begin
      strobeCnt <= '0;
    end else if (decValid) begin
      strobeCnt <= nextCnt[PERIOD_W-1:0];
    end
  end
endmodule

// File: rtl/ber_count_dp.sv
module ber_count_dp
  import ber_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int ERR_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  winCtrl_t         ctrl,
  input  logic [ERR_W-1:0] errCnt,
  output logic [CNT_W-1:0] liveCount,
  output logic [CNT_W-1:0] lastCount
);
  logic [CNT_W:0]   sumWide;
  logic [CNT_W-1:0] sumSat;

  assign sumWide = {1'b0, liveCount} + (CNT_W+1)'(errCnt);
  assign sumSat  = sumWide[CNT_W] ? '1 : sumWide[CNT_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveCount <= '0;
      lastCount <= '0;
    end else if (ctrl.accum) begin
      if (ctrl.rollover) begin
        lastCount <= sumSat;
        liveCount <= '0;
      end else begin
        liveCount <= sumSat;
      end
    end
  end
endmodule

// File: rtl/ber_reencode_estimator.sv
module ber_reencode_estimator
  import ber_pkg::*;
#(
  parameter int N_CODED   = 2,
  parameter int CONSTR    = 7,
  parameter int SOFT_W    = 3,
  parameter int BPS       = 2,
  parameter int TRACEBACK = 36,
  parameter int PERIOD_W  = 24,
  parameter int CNT_W     = 16,
  parameter logic [N_CODED-1:0][CONSTR-1:0] POLY = {7'o133, 7'o171}
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          decValid,
  input  logic [BPS-1:0]                decBits,
  input  logic [BPS*N_CODED*SOFT_W-1:0] rxSyms,
  input  logic [PERIOD_W-1:0]           period,
  output logic [CNT_W-1:0]              liveCount,
  output logic [CNT_W-1:0]              lastCount
);
  localparam int ERR_W = $clog2(BPS*N_CODED+1);

  generate
    if ((TRACEBACK % BPS) != 0) begin : g_bad_traceback
      $error("TRACEBACK must be a multiple of BPS");
    end
  endgenerate

  winCtrl_t         ctrl;
  logic [ERR_W-1:0] errCnt;

  ber_reencode #(
    .N_CODED(N_CODED), .CONSTR(CONSTR), .SOFT_W(SOFT_W),
    .BPS(BPS), .POLY(POLY), .ERR_W(ERR_W)
  ) u_reencode (
    .clk(clk), .rstN(rstN), .decValid(decValid),
    .decBits(decBits), .rxSyms(rxSyms), .errCnt(errCnt)
  );

  ber_window_ctrl #(.PERIOD_W(PERIOD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .decValid(decValid),
    .period(period), .ctrl(ctrl)
  );

  ber_count_dp #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .errCnt(errCnt),
    .liveCount(liveCount), .lastCount(lastCount)
  );
endmodule

// File: rtl/ber_reencode_estimator_chk.sv
module ber_reencode_estimator_chk #(
  parameter int SYM_W    = 12,
  parameter int MAX_ERR  = 4,
  parameter int PERIOD_W = 24,
  parameter int CNT_W    = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                decValid,
  input logic [SYM_W-1:0]    rxSyms,
  input logic [PERIOD_W-1:0] period,
  input logic [CNT_W-1:0]    liveCount,
  input logic [CNT_W-1:0]    lastCount
);
  // R1: counts held at zero under reset
  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_zero_r1: assert (liveCount == '0 && lastCount == '0);
    end
  end

  // R5: no strobe, no change
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |=> ($stable(liveCount) && $stable(lastCount)));

  // R4: live count steps up by at most one strobe's symbol count
  p_live_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && period == '0) |=>
      (({1'b0, liveCount} >= {1'b0, $past(liveCount)}) &&
       ({1'b0, liveCount} <= {1'b0, $past(liveCount)} + (CNT_W+1)'(MAX_ERR))));

  // R3: fully erased strobe adds nothing
  p_erased_r3: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && rxSyms == '0 && period == '0) |=> $stable(liveCount));

  // R7: no rollover while period is zero
  p_no_roll_r7: assert property (@(posedge clk) disable iff (!rstN)
    (period == '0) |=> $stable(lastCount));

  // R6: held count only moves at a window close, which clears the live count
  p_roll_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lastCount) |-> (liveCount == '0));

  // R8: a saturated live count stays saturated without a rollover
  p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (liveCount == '1 && period == '0) |=> (liveCount == '1));
endmodule

bind ber_reencode_estimator ber_reencode_estimator_chk #(
  .SYM_W(BPS*N_CODED*SOFT_W), .MAX_ERR(BPS*N_CODED),
  .PERIOD_W(PERIOD_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .decValid(decValid), .rxSyms(rxSyms),
  .period(period), .liveCount(liveCount), .lastCount(lastCount)
);

// File: tb/ber_reencode_estimator_test.sv
`timescale 1ns/1ps
module ber_reencode_estimator_test;
  localparam int N  = 2;
  localparam int K  = 7;
  localparam int SW = 3;
  localparam int BPS = 2;
  localparam int PW = 24;
  localparam int CW = 16;
  localparam int SYMW = BPS*N*SW;
  localparam logic [N-1:0][K-1:0] POLY = {7'o133, 7'o171};

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            decValid = 1'b0;
  logic [BPS-1:0]  decBits = '0;
  logic [SYMW-1:0] rxSyms = '0;
  logic [PW-1:0]   period = '0;
  logic [CW-1:0]   liveCount, lastCount;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [63:0] mHist = '0;
  int mLive = 0, mLast = 0, mTally = 0;

  always #4 clk = ~clk;

  ber_reencode_estimator #(
    .N_CODED(N), .CONSTR(K), .SOFT_W(SW), .BPS(BPS),
    .TRACEBACK(36), .PERIOD_W(PW), .CNT_W(CW), .POLY(POLY)
  ) uut (
    .clk(clk), .rstN(rstN), .decValid(decValid), .decBits(decBits),
    .rxSyms(rxSyms), .period(period),
    .liveCount(liveCount), .lastCount(lastCount)
  );

  // Code bits, index b*N + (N-1-s) for bit b and polynomial slot s
  function automatic logic [BPS*N-1:0] encodeAll(input logic [63:0] h,
                                                input logic [BPS-1:0] bits);
    logic [BPS*N-1:0] out = '0;
    for (int b = BPS-1; b >= 0; b--) begin
      h = {h[62:0], bits[b]};
      for (int s = 0; s < N; s++) begin
        logic c = 1'b0;
        for (int m = 0; m < K; m++) c ^= h[m] & POLY[N-1-s][K-1-m];
        out[b*N + N-1-s] = c;
      end
    end
    return out;
  endfunction

  function automatic int expErr(input logic [63:0] h, input logic [BPS-1:0] bits,
                                input logic [SYMW-1:0] syms);
    logic [BPS*N-1:0] cb = encodeAll(h, bits);
    int e = 0;
    for (int i = 0; i < BPS*N; i++) begin
      logic [SW-1:0] v = syms[i*SW +: SW];
      if (v != '0 && v[SW-1] != cb[i]) e++;
    end
    return e;
  endfunction

  function automatic logic [SYMW-1:0] genSyms(input logic [63:0] h,
      input logic [BPS-1:0] bits, input int errPct, input int erasePct);
    logic [BPS*N-1:0] cb = encodeAll(h, bits);
    logic [SYMW-1:0] out = '0;
    for (int i = 0; i < BPS*N; i++) begin
      int r = int'($urandom % 100);
      logic t;
      logic [SW-1:0] v;
      if (r < erasePct) v = '0;
      else begin
        t = (r < erasePct + errPct) ? ~cb[i] : cb[i];
        if (t) v = {1'b1, (SW-1)'($urandom)};
        else   v = {1'b0, (SW-1)'(1 + ($urandom % ((1 << (SW-1)) - 1)))};
      end
      out[i*SW +: SW] = v;
    end
    return out;
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, update the model, check after the edge
  task automatic step(input logic v, input logic [BPS-1:0] bits,
                      input logic [SYMW-1:0] syms, input string req);
    decValid = v; decBits = bits; rxSyms = syms;
    if (v) begin
      int e = expErr(mHist, bits, syms);
      int s = mLive + e;
      if (s > 65535) s = 65535;
      for (int b = BPS-1; b >= 0; b--) mHist = {mHist[62:0], bits[b]};
      if (period != 0) begin
        mTally++;
        if (mTally >= int'(period)) begin
          mLast = s; mLive = 0; mTally = 0;
        end else mLive = s;
      end else begin
        mTally = 0; mLive = s;
      end
    end else if (period == 0) mTally = 0;
    @(negedge clk);
    check(req, int'(liveCount), mLive, "liveCount");
    check(req, int'(lastCount), mLast, "lastCount");
  endtask

  task automatic randStep(input int validPct, input int errPct, input int erasePct,
                          input string req);
    logic [BPS-1:0] bits = BPS'($urandom);
    logic v = (int'($urandom % 100) < validPct);
    step(v, bits, genSyms(mHist, bits, errPct, erasePct), req);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", int'(liveCount), 0, "liveCount in reset");
    check("R1", int'(lastCount), 0, "lastCount in reset");
    rstN = 1'b1;
    @(negedge clk);

    // R2: known vector, bits 1 then 0 from clear history give code 11 then 01;
    // all symbols strong zero (3'b011) so three mismatch
    step(1'b1, 2'b10, {4{3'b011}}, "R2");
    check("R2", int'(liveCount), 3, "directed re-encode count");

    // R2: error-free random stream keeps the count flat across strobe seams
    for (int i = 0; i < 40; i++) randStep(100, 0, 0, "R2");
    check("R2", int'(liveCount), 3, "clean stream count");

    // R5: invalid cycles with all-wrong symbols change nothing
    for (int i = 0; i < 20; i++) randStep(0, 100, 0, "R5");

    // R3: fully erased strobes and mixed erasures
    for (int i = 0; i < 20; i++) step(1'b1, BPS'($urandom), '0, "R3");
    for (int i = 0; i < 40; i++) randStep(100, 50, 50, "R3");

    // R4: random errors, gaps and erasures, no windows
    for (int i = 0; i < 300; i++) randStep(70, 20, 10, "R4");

    // R6: fixed windows
    period = 24'd5;
    for (int i = 0; i < 400; i++) randStep(70, 20, 10, "R6");
    // R6: period of one closes on every strobe
    period = 24'd1;
    for (int i = 0; i < 60; i++) randStep(80, 30, 10, "R6");
    // R6: period changes mid-window, including below the current tally
    for (int j = 0; j < 30; j++) begin
      period = PW'(1 + ($urandom % 6));
      for (int i = 0; i < 10; i++) randStep(70, 25, 10, "R6");
    end

    // R7: period zero holds the previous total
    period = '0;
    for (int i = 0; i < 100; i++) randStep(80, 30, 5, "R7");

    // R8: drive the live count to its ceiling
    for (int i = 0; i < 16500; i++) randStep(100, 100, 0, "R8");
    check("R8", int'(liveCount), 65535, "saturated liveCount");
    period = 24'd1;
    randStep(100, 100, 0, "R8");
    check("R8", int'(lastCount), 65535, "saturated window total");
    check("R8", int'(liveCount), 0, "live after saturated close");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule